// File: doc/BRIEF.md
# UART Automatic Powerdown Controller

This block decides, cycle by cycle, when the transmit half and the receive half of a 16550-style UART may have their clocks or power gated. It watches status signals from the UART datapath and produces two separate powerdown flags, one for each half. The datapath, baud generator and FIFOs stay outside the block. The block only reads their status and drives the gating controls.

The transmitter is gated whenever its holding buffer and its shift register are both empty. A host write to the transmit buffer wakes it again. The receiver is gated when its FIFO is empty and its state machine is idle, waiting for a start bit. Any change on the serial input line wakes it. That line goes through a synchroniser, so the receiver is running again within a few clocks. This is well inside the first half of a start bit at any normal oversampling ratio. A hold window then keeps the receiver awake long enough to latch the start bit. The ring-indicator interrupt passes straight through and is never gated. A single enable input permits automatic powerdown. When the enable is cleared, both halves are forced awake.

All ports are plain control and status pins. No data stream crosses the block, so it has no valid/ready handshake and no back-pressure.

Top module: `uart_apd_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, tx_pd and rx_pd are both 0.
- R2: When apd_en is 0, tx_pd and rx_pd are 0 one clock later, whatever the status inputs are.
- R3: With apd_en=1, thr_empty=1, tsr_empty=1 and thr_wr=0 sampled at a clock edge, tx_pd is 1 after that edge.
- R4: If thr_empty or tsr_empty is 0 at a clock edge, tx_pd is 0 after that edge.
- R5: thr_wr=1 at a clock edge makes tx_pd 0 after that edge, even when both empty inputs are 1 in the same cycle.
- R6: With apd_en=1, rx_fifo_empty=1, rx_wait_start=1 and no wake hold pending, rx_pd is 1 one clock later.
- R7: If rx_fifo_empty or rx_wait_start is 0 at a clock edge, rx_pd is 0 after that edge.
- R8: A rising change of rxd sampled at clock edge E1 makes rx_pd 0 after edge E3 (two synchroniser stages plus one flag register). rx_pd is still 1 after E2.
- R9: A falling change of rxd wakes the receiver with the same three-edge timing as R8.
- R10: After an rxd-change wake, rx_pd stays 0 for WAKE_HOLD further edges (default 16), even if the sleep conditions hold. It returns to 1 at the edge after that.
- R11: ri_irq_out equals ri_irq_in at all times, whether or not either half is powered down.
- R12: The halves are independent: thr_wr and the transmit empties do not change rx_pd, and rxd changes do not change tx_pd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| apd_en | input | 1 | Permits automatic powerdown |
| thr_empty | input | 1 | Transmit holding buffer empty |
| tsr_empty | input | 1 | Transmit shift register empty |
| thr_wr | input | 1 | Host write strobe to the transmit buffer |
| rx_fifo_empty | input | 1 | Receive FIFO empty |
| rx_wait_start | input | 1 | Receiver idle, waiting for a start bit |
| rxd | input | 1 | Raw serial receive line (asynchronous) |
| ri_irq_in | input | 1 | Ring-indicator interrupt from the modem-status logic |
| tx_pd | output | 1 | Transmitter powerdown flag |
| rx_pd | output | 1 | Receiver powerdown flag |
| ri_irq_out | output | 1 | Ring-indicator interrupt, never gated |

## Verification
Assertions check several rules on every cycle:
- clearing the enable wakes both halves;
- the transmitter sleeps when both of its empties are set and no write is present;
- a write, or a non-empty condition, keeps it awake;
- a detected rxd change, or a pending hold count, keeps the receiver awake.

The bench scenarios cover what the assertions cannot see:
- the exact three-edge latency from a raw rxd change to the wake;
- the length of the hold window before the receiver sleeps again;
- the independence of the two halves;
- the ring-indicator pass-through while both halves are gated.

// File: rtl/uart_apd_pkg.sv
package uart_apd_pkg;
  typedef enum logic {
    PD_AWAKE  = 1'b0,
    PD_ASLEEP = 1'b1
  } pd_state_e;
endpackage

// File: rtl/apd_sync.sv
module apd_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= RST_VAL;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/apd_tx_gate.sv
module apd_tx_gate
  import uart_apd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic apd_en,
  input  logic thr_empty,
  input  logic tsr_empty,
  input  logic thr_wr,
  output logic tx_pd
);
  pd_state_e state_q, state_d;

  always_comb begin
    state_d = PD_AWAKE;
    if (apd_en && !thr_wr && thr_empty && tsr_empty) state_d = PD_ASLEEP;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state_q <= PD_AWAKE;
    else        state_q <= state_d;

  assign tx_pd = (state_q == PD_ASLEEP);

  // R3
  a_r3_tx_sleeps: assert property (@(posedge clk) disable iff (!rst_n)
    (apd_en && thr_empty && tsr_empty && !thr_wr) |=> tx_pd);
  // R4
  a_r4_tx_busy_awake: assert property (@(posedge clk) disable iff (!rst_n)
    !(thr_empty && tsr_empty) |=> !tx_pd);
  // R5
  a_r5_write_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !tx_pd);
endmodule

// File: rtl/apd_rx_gate.sv
module apd_rx_gate
  import uart_apd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_HOLD   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic apd_en,
  input  logic rx_fifo_empty,
  input  logic rx_wait_start,
  input  logic rxd,
  output logic rx_pd
);
  localparam int CNT_W = $clog2(WAKE_HOLD + 1);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(WAKE_HOLD);

  logic rxd_s, rxd_prev, rxd_edge;
  logic [CNT_W-1:0] hold_cnt;
  pd_state_e state_q, state_d;

  apd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rxd_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (rxd),
    .q_sync  (rxd_s)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rxd_prev <= 1'b1;
    else        rxd_prev <= rxd_s;

  assign rxd_edge = rxd_s ^ rxd_prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               hold_cnt <= '0;
    else if (!apd_en)         hold_cnt <= '0;
    else if (rxd_edge)        hold_cnt <= HOLD_LOAD;
    else if (hold_cnt != '0)  hold_cnt <= hold_cnt - 1'b1;

  always_comb begin
    state_d = PD_AWAKE;
    if (apd_en && !rxd_edge && (hold_cnt == '0) && rx_fifo_empty && rx_wait_start)
      state_d = PD_ASLEEP;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state_q <= PD_AWAKE;
    else        state_q <= state_d;

  assign rx_pd = (state_q == PD_ASLEEP);

  // R7
  a_r7_rx_busy_awake: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_fifo_empty && rx_wait_start) |=> !rx_pd);
  // R8, R9
  a_r8_edge_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    rxd_edge |=> !rx_pd);
  // R10
  a_r10_hold_awake: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_cnt != '0) |=> !rx_pd);
endmodule

// File: rtl/uart_apd_ctrl.sv
module uart_apd_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_HOLD   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic apd_en,
  input  logic thr_empty,
  input  logic tsr_empty,
  input  logic thr_wr,
  input  logic rx_fifo_empty,
  input  logic rx_wait_start,
  input  logic rxd,
  input  logic ri_irq_in,
  output logic tx_pd,
  output logic rx_pd,
  output logic ri_irq_out
);
  apd_tx_gate u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .apd_en    (apd_en),
    .thr_empty (thr_empty),
    .tsr_empty (tsr_empty),
    .thr_wr    (thr_wr),
    .tx_pd     (tx_pd)
  );

  apd_rx_gate #(.SYNC_STAGES(SYNC_STAGES), .WAKE_HOLD(WAKE_HOLD)) u_rx (
    .clk           (clk),
    .rst_n         (rst_n),
    .apd_en        (apd_en),
    .rx_fifo_empty (rx_fifo_empty),
    .rx_wait_start (rx_wait_start),
    .rxd           (rxd),
    .rx_pd         (rx_pd)
  );

  // R11: modem-status ring interrupt bypasses all gating
  assign ri_irq_out = ri_irq_in;

  // R2
  a_r2_disable_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    !apd_en |=> (!tx_pd && !rx_pd));
endmodule

// File: tb/uart_apd_ctrl_tb.sv
module uart_apd_ctrl_tb;
  localparam int HOLD = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic apd_en = 1'b0, thr_empty = 1'b0, tsr_empty = 1'b0, thr_wr = 1'b0;
  logic rx_fifo_empty = 1'b0, rx_wait_start = 1'b0, rxd = 1'b1, ri_irq_in = 1'b0;
  logic tx_pd, rx_pd, ri_irq_out;

  always #2 clk = ~clk;

  uart_apd_ctrl #(.SYNC_STAGES(2), .WAKE_HOLD(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .apd_en(apd_en), .thr_empty(thr_empty),
    .tsr_empty(tsr_empty), .thr_wr(thr_wr), .rx_fifo_empty(rx_fifo_empty),
    .rx_wait_start(rx_wait_start), .rxd(rxd), .ri_irq_in(ri_irq_in),
    .tx_pd(tx_pd), .rx_pd(rx_pd), .ri_irq_out(ri_irq_out)
  );

  typedef struct {
    string tag;
    logic  etx;
    logic  erx;
    logic  eri;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic expect_now(input string tag, input logic etx, input logic erx, input logic eri);
    exp_t e;
    e.tag = tag; e.etx = etx; e.erx = erx; e.eri = eri;
    q.push_back(e);
    #1;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: pops expectations and compares against the outputs
  initial begin
    forever begin
      wait (q.size() > 0);
      begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (tx_pd !== e.etx || rx_pd !== e.erx || ri_irq_out !== e.eri) begin
          n_fail++;
          $display("FAIL %s: tx_pd=%b rx_pd=%b ri=%b expected tx_pd=%b rx_pd=%b ri=%b",
                   e.tag, tx_pd, rx_pd, ri_irq_out, e.etx, e.erx, e.eri);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: expired expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(3);
    expect_now("R1 in reset", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    step(1);
    expect_now("R1 after reset", 1'b0, 1'b0, 1'b0);

    // sleep conditions present but enable low
    thr_empty = 1; tsr_empty = 1; rx_fifo_empty = 1; rx_wait_start = 1;
    step(2);
    expect_now("R2 enable low keeps awake", 1'b0, 1'b0, 1'b0);

    apd_en = 1;
    step(1);
    expect_now("R3/R6 both sleep", 1'b1, 1'b1, 1'b0);

    thr_wr = 1;
    step(1);
    expect_now("R5/R12 write with empties wakes tx only", 1'b0, 1'b1, 1'b0);
    thr_wr = 0;
    step(1);
    expect_now("R3 tx sleeps again", 1'b1, 1'b1, 1'b0);

    thr_empty = 0;
    step(1);
    expect_now("R4 holding not empty", 1'b0, 1'b1, 1'b0);
    thr_empty = 1; tsr_empty = 0;
    step(1);
    expect_now("R4 shift not empty", 1'b0, 1'b1, 1'b0);
    tsr_empty = 1;
    step(1);
    expect_now("R3 tx re-sleep", 1'b1, 1'b1, 1'b0);

    rx_fifo_empty = 0;
    step(1);
    expect_now("R7/R12 fifo not empty", 1'b1, 1'b0, 1'b0);
    rx_fifo_empty = 1;
    step(1);
    expect_now("R6 rx re-sleep", 1'b1, 1'b1, 1'b0);
    rx_wait_start = 0;
    step(1);
    expect_now("R7 receiver busy", 1'b1, 1'b0, 1'b0);
    rx_wait_start = 1;
    step(1);
    expect_now("R6 rx re-sleep 2", 1'b1, 1'b1, 1'b0);

    ri_irq_in = 1;
    #1;
    expect_now("R11 ring passes while gated", 1'b1, 1'b1, 1'b1);
    ri_irq_in = 0;
    #1;
    expect_now("R11 ring low while gated", 1'b1, 1'b1, 1'b0);

    // falling change on rxd
    rxd = 0;
    step(2);
    expect_now("R9 still asleep after E2", 1'b1, 1'b1, 1'b0);
    step(1);
    expect_now("R9/R12 falling change wakes rx at E3", 1'b1, 1'b0, 1'b0);
    step(HOLD);
    expect_now("R10 hold window end", 1'b1, 1'b0, 1'b0);
    step(1);
    expect_now("R10 rx sleeps after hold", 1'b1, 1'b1, 1'b0);

    // rising change on rxd
    rxd = 1;
    step(2);
    expect_now("R8 still asleep after E2", 1'b1, 1'b1, 1'b0);
    step(1);
    expect_now("R8 rising change wakes rx at E3", 1'b1, 1'b0, 1'b0);
    step(HOLD / 2);
    expect_now("R10 mid hold", 1'b1, 1'b0, 1'b0);
    step(HOLD / 2 + 1);
    expect_now("R10 sleeps after hold 2", 1'b1, 1'b1, 1'b0);

    apd_en = 0;
    step(1);
    expect_now("R2 disable forces both awake", 1'b0, 1'b0, 1'b0);

    wait (q.size() == 0);
    #1;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule